// File: doc/BRIEF.md
# Directory Home Controller

This block is the home-node directory for a small, fixed group of memory blocks in a distributed shared-memory system. For every block it keeps a directory state (not cached, shared, or held exclusively by one owner), a sharer vector with one bit per processor, and the block's current memory value in a small register file. Processors reach it with coherence requests: read miss, write miss and data write back.

It replies over a single outbound message channel. The messages are data replies, invalidates, and the two requests that recall a block from its owner: a plain fetch, and a fetch that also invalidates the owner's copy. When a block has to come back from its owner, the owner's copy arrives on a separate owner-data channel. Every channel uses a valid/ready handshake.

The controller handles one request at a time. It stays busy, and refuses new requests, until the last outbound message of the current request has been accepted.

Top module: `dirHome`

## Requirements
- R1: After reset every block is not cached, has no sharers and holds memory value zero; `reqReady` is 1, and `outValid`, `ownReady` and `busy` are 0.
- R2: A read miss (`reqKind` 0) to a block that is not cached returns one data message (`outKind` 0) to the requester, carrying the memory value. The block becomes shared, with the requester as its only sharer.
- R3: A write miss (`reqKind` 1) to a block that is not cached returns a data message with the memory value to the requester. The block becomes exclusive, and the requester becomes its sole owner.
- R4: A read miss to a shared block returns the memory value to the requester and adds the requester to the sharers. Existing sharers are kept.
- R5: A write miss to a shared block first sends invalidates (`outKind` 1), one per message, to every sharer other than the requester, in ascending processor number. After that it sends the data message to the requester. The block becomes exclusive, with the requester as its sole owner.
- R6: A read miss to an exclusive block sends a fetch (`outKind` 2) to the owner and waits for the owner's data. That data is written to memory and forwarded to the requester in a data message. The block becomes shared, with both the old owner and the requester as sharers.
- R7: A write miss to an exclusive block sends a fetch-invalidate (`outKind` 3) to the old owner and forwards the owner's returned data to the requester. The requester becomes the sole owner and the block stays exclusive.
- R8: A write back (`reqKind` 2) from the owner of an exclusive block stores the request data in memory, empties the sharer set and makes the block not cached. It produces no message.
- R9: A write back from a processor that does not own the block, or to a block that is not exclusive, has no effect on memory, state or sharers.
- R10: Once a request is accepted, `reqReady` stays 0 and `busy` stays 1 until the request's last message is accepted. An outbound message that is not accepted holds all of its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqKind | input | 2 | 0 read miss, 1 write miss, 2 write back |
| reqProc | input | log2(NUM_PROCS) | Requesting processor |
| reqBlock | input | log2(NUM_BLOCKS) | Block addressed |
| reqData | input | DATA_W | Write-back data |
| outValid | output | 1 | Outbound message present |
| outReady | input | 1 | Outbound message taken |
| outKind | output | 2 | 0 data, 1 invalidate, 2 fetch, 3 fetch-invalidate |
| outProc | output | log2(NUM_PROCS) | Destination processor |
| outBlock | output | log2(NUM_BLOCKS) | Block the message concerns |
| outData | output | DATA_W | Block value for data messages, zero otherwise |
| ownValid | input | 1 | Owner's block data present |
| ownReady | output | 1 | Directory waiting for owner data |
| ownData | input | DATA_W | Block value returned by the owner |
| busy | output | 1 | A request is in progress |

## Verification
The assertions check on every cycle that requests are refused while one is in progress, and that a stalled message holds its fields. They also check that each invalidate skips the requester and goes to a higher processor number than the one before it, that data replies go to the last requester, and that owner data is accepted only while busy and no message is pending. Whether the sharer set and memory value are right after each transition cannot be seen in a single cycle. Only the bench's request chains show it: a later write miss reveals the recorded sharers through the invalidates it sends, a later read reveals the memory value, and an ignored write back is exposed by the messages that follow it.

// File: rtl/dirPkg.sv
package dirPkg;
  typedef enum logic [1:0] {
    DIR_NONE  = 2'd0,
    DIR_SHRD  = 2'd1,
    DIR_OWNED = 2'd2
  } dirState_t;

  localparam logic [1:0] REQ_READ  = 2'd0;
  localparam logic [1:0] REQ_WRITE = 2'd1;
  localparam logic [1:0] REQ_WB    = 2'd2;

  localparam logic [1:0] MSG_DATA     = 2'd0;
  localparam logic [1:0] MSG_INV      = 2'd1;
  localparam logic [1:0] MSG_FETCH    = 2'd2;
  localparam logic [1:0] MSG_FETCHINV = 2'd3;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_INV   = 2'd1,
    SEL_FETCH = 2'd2
  } outSel_t;

  typedef struct packed {
    logic    capture;
    logic    clearInv;
    logic    takeOwner;
    logic    commit;
    logic    wbCommit;
    outSel_t outSel;
  } dirStrobe_t;
endpackage

// File: rtl/dirHomeDatapath.sv
module dirHomeDatapath
  import dirPkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int PW = $clog2(NUM_PROCS),
  localparam int BW = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        strobe,
  input  logic [1:0]        reqKind,
  input  logic [PW-1:0]     reqProc,
  input  logic [BW-1:0]     reqBlock,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] ownData,
  output dirState_t         curState,
  output logic [1:0]        curKind,
  output logic              invPending,
  output logic              invLast,
  output logic              wbLegal,
  output logic [1:0]        outKind,
  output logic [PW-1:0]     outProc,
  output logic [BW-1:0]     outBlock,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0]    memArr [NUM_BLOCKS];
  dirState_t            stArr  [NUM_BLOCKS];
  logic [NUM_PROCS-1:0] shArr  [NUM_BLOCKS];

  logic [1:0]           lKind;
  logic [PW-1:0]        lProc;
  logic [BW-1:0]        lBlock;
  logic [DATA_W-1:0]    lData;
  logic [NUM_PROCS-1:0] invMask;
  logic [DATA_W-1:0]    replyData;
  logic                 useOwner;

  logic [NUM_PROCS-1:0] inMask, reqMask;
  logic [PW-1:0]        invIdx, ownerIdx;

  function automatic logic [PW-1:0] lowestIdx(input logic [NUM_PROCS-1:0] vec);
    logic [PW-1:0] idx;
    idx = '0;
    for (int i = NUM_PROCS - 1; i >= 0; i--) begin
      if (vec[i]) idx = PW'(i);
    end
    return idx;
  endfunction

  always_comb begin
    inMask = '0;
    inMask[reqProc] = 1'b1;
    reqMask = '0;
    reqMask[lProc] = 1'b1;
  end

  assign invIdx     = lowestIdx(invMask);
  assign ownerIdx   = lowestIdx(shArr[lBlock]);
  assign invPending = |invMask;
  assign invLast    = ((invMask & (invMask - 1'b1)) == '0);
  assign curState   = stArr[lBlock];
  assign curKind    = lKind;
  assign wbLegal    = (stArr[lBlock] == DIR_OWNED) && shArr[lBlock][lProc];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lKind     <= REQ_READ;
      lProc     <= '0;
      lBlock    <= '0;
      lData     <= '0;
      invMask   <= '0;
      replyData <= '0;
      useOwner  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        lKind    <= reqKind;
        lProc    <= reqProc;
        lBlock   <= reqBlock;
        lData    <= reqData;
        useOwner <= 1'b0;
        invMask  <= (reqKind == REQ_WRITE && stArr[reqBlock] == DIR_SHRD)
                    ? (shArr[reqBlock] & ~inMask) : '0;
      end
      if (strobe.clearInv) invMask[invIdx] <= 1'b0;
      if (strobe.takeOwner) begin
        replyData <= ownData;
        useOwner  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        memArr[b] <= '0;
        stArr[b]  <= DIR_NONE;
        shArr[b]  <= '0;
      end
    end else begin
      if (strobe.takeOwner && lKind == REQ_READ) memArr[lBlock] <= ownData;
      if (strobe.commit) begin
        if (lKind == REQ_READ) begin
          stArr[lBlock] <= DIR_SHRD;
          shArr[lBlock] <= shArr[lBlock] | reqMask;
        end else begin
          stArr[lBlock] <= DIR_OWNED;
          shArr[lBlock] <= reqMask;
        end
      end
      if (strobe.wbCommit) begin
        memArr[lBlock] <= lData;
        stArr[lBlock]  <= DIR_NONE;
        shArr[lBlock]  <= '0;
      end
    end
  end

  always_comb begin
    outBlock = lBlock;
    outData  = '0;
    outProc  = lProc;
    outKind  = MSG_DATA;
    case (strobe.outSel)
      SEL_INV: begin
        outKind = MSG_INV;
        outProc = invIdx;
      end
      SEL_FETCH: begin
        outKind = (lKind == REQ_READ) ? MSG_FETCH : MSG_FETCHINV;
        outProc = ownerIdx;
      end
      default: begin
        outData = useOwner ? replyData : memArr[lBlock];
      end
    endcase
  end
endmodule

// File: rtl/dirHomeControl.sv
module dirHomeControl
  import dirPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       outReady,
  input  logic       ownValid,
  input  dirState_t  curState,
  input  logic [1:0] curKind,
  input  logic       invPending,
  input  logic       invLast,
  input  logic       wbLegal,
  output logic       reqReady,
  output logic       outValid,
  output logic       ownReady,
  output logic       busy,
  output dirStrobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_DISPATCH, ST_INVAL, ST_FETCH, ST_WAITOWN, ST_REPLY
  } ctlState_t;

  ctlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.outSel = SEL_DATA;
    reqReady  = 1'b0;
    outValid  = 1'b0;
    ownReady  = 1'b0;
    busy      = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          nextState = ST_DISPATCH;
        end
      end
      ST_DISPATCH: begin
        if (curKind != REQ_READ && curKind != REQ_WRITE) begin
          strobe.wbCommit = (curKind == REQ_WB) && wbLegal;
          nextState = ST_IDLE;
        end else if (curState == DIR_OWNED) begin
          nextState = ST_FETCH;
        end else if (invPending) begin
          nextState = ST_INVAL;
        end else begin
          nextState = ST_REPLY;
        end
      end
      ST_INVAL: begin
        outValid = 1'b1;
        strobe.outSel = SEL_INV;
        if (outReady) begin
          strobe.clearInv = 1'b1;
          if (invLast) nextState = ST_REPLY;
        end
      end
      ST_FETCH: begin
        outValid = 1'b1;
        strobe.outSel = SEL_FETCH;
        if (outReady) nextState = ST_WAITOWN;
      end
      ST_WAITOWN: begin
        ownReady = 1'b1;
        if (ownValid) begin
          strobe.takeOwner = 1'b1;
          nextState = ST_REPLY;
        end
      end
      ST_REPLY: begin
        outValid = 1'b1;
        strobe.outSel = SEL_DATA;
        if (outReady) begin
          strobe.commit = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dirHome.sv
module dirHome
  import dirPkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int PW = $clog2(NUM_PROCS),
  localparam int BW = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [PW-1:0]     reqProc,
  input  logic [BW-1:0]     reqBlock,
  input  logic [DATA_W-1:0] reqData,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outKind,
  output logic [PW-1:0]     outProc,
  output logic [BW-1:0]     outBlock,
  output logic [DATA_W-1:0] outData,
  input  logic              ownValid,
  output logic              ownReady,
  input  logic [DATA_W-1:0] ownData,
  output logic              busy
);
  dirStrobe_t strobe;
  dirState_t  curState;
  logic [1:0] curKind;
  logic       invPending, invLast, wbLegal;

  dirHomeControl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .outReady(outReady),
    .ownValid(ownValid), .curState(curState), .curKind(curKind),
    .invPending(invPending), .invLast(invLast), .wbLegal(wbLegal),
    .reqReady(reqReady), .outValid(outValid), .ownReady(ownReady),
    .busy(busy), .strobe(strobe)
  );

  dirHomeDatapath #(
    .NUM_PROCS(NUM_PROCS), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqKind(reqKind),
    .reqProc(reqProc), .reqBlock(reqBlock), .reqData(reqData),
    .ownData(ownData), .curState(curState), .curKind(curKind),
    .invPending(invPending), .invLast(invLast), .wbLegal(wbLegal),
    .outKind(outKind), .outProc(outProc), .outBlock(outBlock),
    .outData(outData)
  );
endmodule

// File: rtl/dirHomeChecker.sv
module dirHomeChecker #(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int PW = $clog2(NUM_PROCS),
  localparam int BW = $clog2(NUM_BLOCKS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqKind,
  input logic [PW-1:0]     reqProc,
  input logic [BW-1:0]     reqBlock,
  input logic [DATA_W-1:0] reqData,
  input logic              outValid,
  input logic              outReady,
  input logic [1:0]        outKind,
  input logic [PW-1:0]     outProc,
  input logic [BW-1:0]     outBlock,
  input logic [DATA_W-1:0] outData,
  input logic              ownValid,
  input logic              ownReady,
  input logic [DATA_W-1:0] ownData,
  input logic              busy
);
  logic [PW-1:0] lastReq, lastInv;
  logic          invSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastReq <= '0;
      lastInv <= '0;
      invSeen <= 1'b0;
    end else if (reqValid && reqReady) begin
      lastReq <= reqProc;
      invSeen <= 1'b0;
    end else if (outValid && outReady && outKind == 2'd1) begin
      lastInv <= outProc;
      invSeen <= 1'b1;
    end
  end

  // R10: no second request right after one is taken
  a_r10_one_at_a_time: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R10: a stalled message holds its fields
  a_r10_hold_message: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outKind) && $stable(outProc)
      && $stable(outBlock) && $stable(outData));

  // R10: an idle directory emits nothing
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid && !ownReady);

  // R5: invalidates never target the requester
  a_r5_skip_requester: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outKind == 2'd1 |-> outProc != lastReq);

  // R5: invalidates go out in ascending processor order
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outKind == 2'd1 && invSeen |-> outProc > lastInv);

  // R2: data replies go to the requester
  a_r2_data_to_requester: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outKind == 2'd0 |-> outProc == lastReq);

  // R6: owner data taken only while busy with no message pending
  a_r6_owner_wait: assert property (@(posedge clk) disable iff (!rstN)
    ownReady |-> busy && !outValid);
endmodule

bind dirHome dirHomeChecker #(
  .NUM_PROCS(NUM_PROCS), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/dirHome_tb.sv
module dirHome_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [1:0]  reqKind;
  logic [1:0]  reqProc;
  logic [2:0]  reqBlock;
  logic [15:0] reqData;
  logic        outValid;
  logic        outReady;
  logic [1:0]  outKind;
  logic [1:0]  outProc;
  logic [2:0]  outBlock;
  logic [15:0] outData;
  logic        ownValid;
  logic        ownReady;
  logic [15:0] ownData;
  logic        busy;

  int total = 0;
  int bad   = 0;
  logic [15:0] pendOwn = '0;
  logic        bp = 1'b0;
  int          cyc = 0;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  proc;
    logic [2:0]  blk;
    logic [15:0] data;
    logic [7:0]  tag;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;

  dirHome u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqProc(reqProc), .reqBlock(reqBlock),
    .reqData(reqData), .outValid(outValid), .outReady(outReady),
    .outKind(outKind), .outProc(outProc), .outBlock(outBlock),
    .outData(outData), .ownValid(ownValid), .ownReady(ownReady),
    .ownData(ownData), .busy(busy)
  );

  task automatic check(input bit ok, input int tag, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic expect_msg(input logic [1:0] k, input logic [1:0] p,
                            input logic [2:0] b, input logic [15:0] d, input int tag);
    exp_t e;
    e.kind = k; e.proc = p; e.blk = b; e.data = d; e.tag = 8'(tag);
    expQ.push_back(e);
  endtask

  // monitor: compare every accepted message against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, 10, {outKind, outProc, outBlock, outData}, 0, "unexpected message");
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(outKind == e.kind && outProc == e.proc && outBlock == e.blk && outData == e.data,
                int'(e.tag), {9'd0, outKind, outProc, outBlock, outData},
                {9'd0, e.kind, e.proc, e.blk, e.data}, "message kind/proc/block/data");
        end
      end
    end
  end

  // owner model: answers fetch and fetch-invalidate with pendOwn
  initial begin
    ownValid = 1'b0;
    ownData  = '0;
    forever begin
      @(negedge clk);
      if (rstN && outValid && outReady && outKind[1]) begin
        ownData  = pendOwn;
        ownValid = 1'b1;
        do @(negedge clk); while (!ownReady);
        @(posedge clk);
        #1 ownValid = 1'b0;
      end
    end
  end

  // outbound backpressure
  initial begin
    outReady = 1'b1;
    forever begin
      @(posedge clk);
      #1 cyc++;
      outReady = bp ? (cyc % 3 == 0) : 1'b1;
    end
  end

  task automatic doReq(input logic [1:0] k, input logic [1:0] p, input logic [2:0] b,
                       input logic [15:0] d, input logic [15:0] own);
    pendOwn = own;
    @(negedge clk);
    reqKind = k; reqProc = p; reqBlock = b; reqData = d; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1 reqValid = 1'b0;
    // R10: busy and not ready once a request is in progress
    check(busy && !reqReady, 10, {busy, reqReady}, 2'b10, "busy after accept");
    do @(negedge clk); while (busy);
    check(expQ.size() == 0, 10, expQ.size(), 0, "messages still owed at idle");
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqProc = '0; reqBlock = '0; reqData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check(reqReady == 1'b1, 1, reqReady, 1, "reqReady at reset");
    check(outValid == 1'b0 && ownReady == 1'b0 && busy == 1'b0, 1,
          {outValid, ownReady, busy}, 0, "quiet outputs at reset");
    rstN = 1'b1;

    // R2 (and R1 zero memory): read of uncached block
    expect_msg(2'd0, 2'd1, 3'd3, 16'h0000, 2);
    doReq(2'd0, 2'd1, 3'd3, 16'h0, 16'h0);
    // R5: write to shared {1} by P2 invalidates P1
    expect_msg(2'd1, 2'd1, 3'd3, 16'h0000, 5);
    expect_msg(2'd0, 2'd2, 3'd3, 16'h0000, 5);
    doReq(2'd1, 2'd2, 3'd3, 16'h0, 16'h0);
    // R8: owner P2 writes back
    doReq(2'd2, 2'd2, 3'd3, 16'hA5A5, 16'h0);
    // R8, R2: memory holds write-back value, block uncached
    expect_msg(2'd0, 2'd0, 3'd3, 16'hA5A5, 8);
    doReq(2'd0, 2'd0, 3'd3, 16'h0, 16'h0);
    // R4: more readers join
    expect_msg(2'd0, 2'd3, 3'd3, 16'hA5A5, 4);
    doReq(2'd0, 2'd3, 3'd3, 16'h0, 16'h0);
    expect_msg(2'd0, 2'd2, 3'd3, 16'hA5A5, 4);
    doReq(2'd0, 2'd2, 3'd3, 16'h0, 16'h0);
    // R5: sharers {0,2,3}, P2 writes under backpressure: inv 0, inv 3, data 2
    bp = 1'b1;
    expect_msg(2'd1, 2'd0, 3'd3, 16'h0000, 5);
    expect_msg(2'd1, 2'd3, 3'd3, 16'h0000, 5);
    expect_msg(2'd0, 2'd2, 3'd3, 16'hA5A5, 5);
    doReq(2'd1, 2'd2, 3'd3, 16'h0, 16'h0);
    bp = 1'b0;
    // R9: non-owner write back ignored
    doReq(2'd2, 2'd1, 3'd3, 16'h1111, 16'h0);
    // R6, R9: read of exclusive block still owned by P2
    expect_msg(2'd2, 2'd2, 3'd3, 16'h0000, 6);
    expect_msg(2'd0, 2'd0, 3'd3, 16'h7777, 6);
    doReq(2'd0, 2'd0, 3'd3, 16'h0, 16'h7777);
    // R6: sharers now {0,2}, memory 7777
    expect_msg(2'd1, 2'd0, 3'd3, 16'h0000, 6);
    expect_msg(2'd1, 2'd2, 3'd3, 16'h0000, 6);
    expect_msg(2'd0, 2'd1, 3'd3, 16'h7777, 6);
    doReq(2'd1, 2'd1, 3'd3, 16'h0, 16'h0);
    // R7: write to exclusive block owned by P1
    bp = 1'b1;
    expect_msg(2'd3, 2'd1, 3'd3, 16'h0000, 7);
    expect_msg(2'd0, 2'd3, 3'd3, 16'h2222, 7);
    doReq(2'd1, 2'd3, 3'd3, 16'h0, 16'h2222);
    bp = 1'b0;
    // R7: P3 is now the owner
    expect_msg(2'd2, 2'd3, 3'd3, 16'h0000, 7);
    expect_msg(2'd0, 2'd0, 3'd3, 16'h3333, 7);
    doReq(2'd0, 2'd0, 3'd3, 16'h0, 16'h3333);
    // R9: write back to a shared block ignored
    doReq(2'd2, 2'd0, 3'd3, 16'h9999, 16'h0);
    expect_msg(2'd0, 2'd1, 3'd3, 16'h3333, 9);
    doReq(2'd0, 2'd1, 3'd3, 16'h0, 16'h0);
    // R9, R5: sharers {0,1,3} intact; P1 writes
    expect_msg(2'd1, 2'd0, 3'd3, 16'h0000, 9);
    expect_msg(2'd1, 2'd3, 3'd3, 16'h0000, 9);
    expect_msg(2'd0, 2'd1, 3'd3, 16'h3333, 9);
    doReq(2'd1, 2'd1, 3'd3, 16'h0, 16'h0);
    // R3: write to uncached block 5 makes P0 owner
    expect_msg(2'd0, 2'd0, 3'd5, 16'h0000, 3);
    doReq(2'd1, 2'd0, 3'd5, 16'h0, 16'h0);
    expect_msg(2'd2, 2'd0, 3'd5, 16'h0000, 3);
    expect_msg(2'd0, 2'd2, 3'd5, 16'h0BEE, 3);
    doReq(2'd0, 2'd2, 3'd5, 16'h0, 16'h0BEE);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, 10, 0, 1, "watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule